// File: doc/BRIEF.md
# Write-Only I2C Command Receiver

This block is an I2C target that only listens. It oversamples the SCL and SDA lines with the system clock and recognises START and STOP conditions. It decodes the 7-bit address against two values: a device address that software supplies on a port, and a fixed broadcast address. Only write transfers are acknowledged. A read request, or an address that matches neither value, is never acknowledged.

After a matching write address, the block collects exactly three data bytes into a 24-bit command word. The first byte received lands in the top eight bits. It acknowledges each of these three bytes and refuses any further byte in the same transfer. The finished word leaves on a valid/ready stream port. The I2C bus cannot be stalled, because the block does not stretch the clock, so the output holds a single word:
- The word stays valid, and its data stays stable, until the consumer raises ready.
- If the consumer is still holding off when the next word completes, the newer word replaces the pending one.

With ready tied high, the valid signal is a one-cycle strobe.

SDA is driven as an open-drain enable: `sda_oe` high pulls the line low. A busy flag shows when a command word is partly received.

Top module: `i2c_cmd_rx`

## Requirements
- R1: While reset is asserted, `sda_oe`, `word_valid` and `xfer_busy` are all 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP, bytes clocked without a new START are not acknowledged, produce no word and leave `xfer_busy` at 0.
- R3: The first byte after START holds the 7-bit address in bits 7..1 and the direction in bit 0, with 0 meaning write. The byte is acknowledged when the address equals `dev_addr` and bit 0 is 0. The acknowledge pulls SDA low for the 9th clock. A new `dev_addr` value takes effect for the next transfer.
- R4: A write to the broadcast address 7'h73 is acknowledged in the same way, whatever the value of `dev_addr`.
- R5: An address matching neither value is not acknowledged, and none of the data bytes that follow it are acknowledged.
- R6: When bit 0 of the address byte is 1, SDA stays released during the 9th clock, even if the address matches.
- R7: After a matching write address, each of the first three data bytes is acknowledged. After the third byte, `word_data` presents {byte1, byte2, byte3} with byte1 in bits 23..16, and `word_valid` rises.
- R8: A fourth or later data byte in the same transfer is not acknowledged and does not create a new word.
- R9: `xfer_busy` rises once the first data bit of the first data byte has been sampled. It falls when the third byte completes, or on a START or a STOP.
- R10: A repeated START discards a partly received word and restarts address reception.
- R11: `sda_oe` changes only while SCL is low, so during the high phase of an acknowledge clock SDA is stable.
- R12: While `word_valid` is high and `word_ready` is low, `word_valid` stays high and `word_data` stays stable. A word completed in that state replaces the pending one. A cycle with both high consumes the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| dev_addr | input | 7 | Device address the block answers to |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| xfer_busy | output | 1 | A command word is partly received |
| word_valid | output | 1 | Stream valid for the received word |
| word_ready | input | 1 | Stream ready from the consumer |
| word_data | output | 24 | Received command word, first byte in the top bits |

## Verification
The hardest situations to reach from the ports are a repeated START that lands inside a partly received word, and a completed word that arrives while the previous one is still held back by the consumer. The bench reaches both with a bit-level bus master. For the first, the master sends a START after two data bytes, then a full new transfer, and checks that only the new three bytes come out. For the second, the master runs two complete transfers with `word_ready` held low, then releases ready and checks that only the second word is handed over. During every acknowledge clock, the bench samples SDA on each system clock of the high phase to confirm that it holds steady.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK_SET,
    ST_ACK_HOLD,
    ST_ACK_DONE,
    ST_SKIP
  } rx_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_sh[STAGES-1];
      sda_q <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
#(
  parameter int          WORD_BYTES = 3,
  parameter logic [6:0]  BCAST_ADDR = 7'h73,
  localparam int         WORD_W     = WORD_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [6:0]        dev_addr,
  output logic              sda_oe,
  output logic              busy,
  output logic              word_load,
  output logic [WORD_W-1:0] word_bits
);

  localparam int             BC_W     = $clog2(WORD_BYTES + 1);
  localparam logic [BC_W-1:0] LAST_IDX = BC_W'(WORD_BYTES - 1);
  localparam logic [BC_W-1:0] FULL_CNT = BC_W'(WORD_BYTES);

  rx_state_e         state;
  logic [2:0]        bit_cnt;
  logic [BC_W-1:0]   byte_cnt;
  logic [6:0]        shreg;
  logic [WORD_W-1:0] word_acc;
  logic              ack_en;
  logic              go_data;

  logic [BYTE_W-1:0] rx_byte;
  logic              addr_hit;
  logic              last_bit;

  assign rx_byte  = {shreg, sda_s};
  assign addr_hit = !sda_s && ((shreg == dev_addr) || (shreg == BCAST_ADDR));
  assign last_bit = (bit_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      shreg     <= '0;
      word_acc  <= '0;
      ack_en    <= 1'b0;
      go_data   <= 1'b0;
      sda_oe    <= 1'b0;
      busy      <= 1'b0;
      word_load <= 1'b0;
    end else begin
      word_load <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        ack_en   <= 1'b0;
        sda_oe   <= 1'b0;
        busy     <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        busy   <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            shreg   <= {shreg[5:0], sda_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (last_bit) begin
              ack_en  <= addr_hit;
              go_data <= addr_hit;
              state   <= ST_ACK_SET;
            end
          end
          ST_DATA: if (scl_rise) begin
            shreg   <= {shreg[5:0], sda_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd0 && byte_cnt == '0) busy <= 1'b1;
            if (last_bit) begin
              go_data <= 1'b1;
              state   <= ST_ACK_SET;
              if (byte_cnt != FULL_CNT) begin
                ack_en   <= 1'b1;
                byte_cnt <= byte_cnt + 1'b1;
                word_acc <= (word_acc << BYTE_W) | WORD_W'(rx_byte);
                if (byte_cnt == LAST_IDX) begin
                  word_load <= 1'b1;
                  busy      <= 1'b0;
                end
              end else begin
                ack_en <= 1'b0;
              end
            end
          end
          ST_ACK_SET: if (scl_fall) begin
            sda_oe <= ack_en;
            state  <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_rise) state <= ST_ACK_DONE;
          ST_ACK_DONE: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= go_data ? ST_DATA : ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign word_bits = word_acc;

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R11

  AST_DRIVE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe)); // R11

  AST_READ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && scl_rise && last_bit && sda_s && !start_det && !stop_det) |=> !ack_en); // R6

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    word_load |-> !busy); // R9

  AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && !busy)); // R10

endmodule

// File: rtl/i2c_word_hold.sv
module i2c_word_hold #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data))); // R12

endmodule

// File: rtl/i2c_cmd_rx.sv
module i2c_cmd_rx #(
  parameter int         SYNC_STAGES = 2,
  parameter int         WORD_BYTES  = 3,
  parameter logic [6:0] BCAST_ADDR  = 7'h73,
  localparam int        WORD_W      = WORD_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [6:0]        dev_addr,
  output logic              sda_oe,
  output logic              xfer_busy,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [WORD_W-1:0] word_data
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic word_load;
  logic [WORD_W-1:0] word_bits;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rx_ctrl #(.WORD_BYTES(WORD_BYTES), .BCAST_ADDR(BCAST_ADDR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_addr  (dev_addr),
    .sda_oe    (sda_oe),
    .busy      (xfer_busy),
    .word_load (word_load),
    .word_bits (word_bits)
  );

  i2c_word_hold #(.W(WORD_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (word_load),
    .load_data (word_bits),
    .ready     (word_ready),
    .valid     (word_valid),
    .data      (word_data)
  );

endmodule

// File: tb/i2c_cmd_rx_test.sv
module i2c_cmd_rx_test;

  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 10;
  localparam logic [6:0] DEV        = 7'h2A;
  localparam logic [6:0] BCAST      = 7'h73;
  localparam int         NVEC       = 7;

  // {addr[32:26], rw[25], data[24:1], expect_ack[0]}
  localparam logic [32:0] VEC [NVEC] = '{
    {DEV,     1'b0, 24'h301234, 1'b1},
    {BCAST,   1'b0, 24'hF0FFFF, 1'b1},
    {7'h2B,   1'b0, 24'h123456, 1'b0},
    {DEV,     1'b1, 24'h0F0F0F, 1'b0},
    {BCAST,   1'b1, 24'hABCDEF, 1'b0},
    {DEV,     1'b0, 24'h000000, 1'b1},
    {DEV,     1'b0, 24'hAA55A5, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic word_ready = 1'b1;
  logic [6:0] dev_addr = DEV;
  logic sda_oe, xfer_busy, word_valid;
  logic [23:0] word_data;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;
  int got_cnt = 0;
  int viol = 0;
  logic [23:0] got_word = '0;
  logic oe_prev = 1'b0;
  bit done = 1'b0;

  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cmd_rx uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .dev_addr   (dev_addr),
    .sda_oe     (sda_oe),
    .xfer_busy  (xfer_busy),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_data  (word_data)
  );

  always @(negedge clk) begin
    if (word_valid && word_ready) begin
      got_cnt++;
      got_word = word_data;
    end
    if (sda_oe && !oe_prev && m_scl) viol++;
    oe_prev = sda_oe;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!m_scl) begin
      m_sda = 1'b1; wait_clk(Q);
      m_scl = 1'b1; wait_clk(Q);
    end
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    m_scl = 1'b0;
    m_sda = 1'b0; wait_clk(Q);
    m_scl = 1'b1; wait_clk(Q);
    m_sda = 1'b1; wait_clk(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked, output logic steady);
    logic first;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_clk(Q);
      m_scl = 1'b1; wait_clk(2*Q);
      m_scl = 1'b0; wait_clk(Q);
    end
    m_sda = 1'b1; wait_clk(Q);
    m_scl = 1'b1;
    wait_clk(1);
    first = sda_line;
    steady = 1'b1;
    for (int k = 1; k < 2*Q; k++) begin
      wait_clk(1);
      if (sda_line != first) steady = 1'b0;
    end
    acked = !first;
    m_scl = 1'b0; wait_clk(Q);
  endtask

  task automatic xfer(input logic [6:0] a, input logic [23:0] d);
    logic ak, st;
    bus_start();
    send_byte({a, 1'b0}, ak, st);
    for (int b = 0; b < 3; b++) send_byte(d[23-8*b -: 8], ak, st);
    bus_stop();
  endtask

  initial begin
    logic [32:0] vec;
    logic ak, st;
    int base;

    wait_clk(5);
    check(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
    check(word_valid == 1'b0, "R1 word_valid in reset", word_valid, 0);
    check(xfer_busy == 1'b0, "R1 xfer_busy in reset", xfer_busy, 0);
    rst_n = 1'b1;
    wait_clk(5);

    for (int v = 0; v < NVEC; v++) begin
      vec = VEC[v];
      base = got_cnt;
      bus_start();
      send_byte({vec[32:26], vec[25]}, ak, st);
      check(ak == vec[0], "R3/R4/R5/R6 address ack", ak, vec[0]);
      check(st, "R11 address ack slot steady", st, 1);
      for (int b = 0; b < 3; b++) begin
        send_byte(vec[24-8*b -: 8], ak, st);
        check(ak == vec[0], "R7/R5/R6 data ack", ak, vec[0]);
        check(st, "R11 data ack slot steady", st, 1);
      end
      bus_stop();
      check(got_cnt == base + int'(vec[0]), "R7 word count", got_cnt - base, vec[0]);
      if (vec[0]) check(got_word == vec[24:1], "R7 word value", got_word, vec[24:1]);
      check(word_valid == 1'b0, "R7 strobe ends with ready high", word_valid, 0);
    end

    // R8: extra bytes refused
    base = got_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ak, st);
    send_byte(8'h01, ak, st);
    send_byte(8'h02, ak, st);
    send_byte(8'h03, ak, st);
    check(ak == 1'b1, "R8 third byte acked", ak, 1);
    send_byte(8'h04, ak, st);
    check(ak == 1'b0, "R8 fourth byte not acked", ak, 0);
    send_byte(8'h05, ak, st);
    check(ak == 1'b0, "R8 fifth byte not acked", ak, 0);
    bus_stop();
    check(got_cnt == base + 1, "R8 single word", got_cnt - base, 1);
    check(got_word == 24'h010203, "R8 word value", got_word, 24'h010203);

    // R9: busy window
    bus_start();
    send_byte({DEV, 1'b0}, ak, st);
    check(xfer_busy == 1'b0, "R9 busy low before data", xfer_busy, 0);
    send_byte(8'hC1, ak, st);
    check(xfer_busy == 1'b1, "R9 busy after first byte", xfer_busy, 1);
    send_byte(8'hC2, ak, st);
    check(xfer_busy == 1'b1, "R9 busy after second byte", xfer_busy, 1);
    send_byte(8'hC3, ak, st);
    check(xfer_busy == 1'b0, "R9 busy low after third byte", xfer_busy, 0);
    bus_stop();

    // R10: repeated start discards partial word
    base = got_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ak, st);
    send_byte(8'h77, ak, st);
    send_byte(8'h88, ak, st);
    bus_start();
    check(xfer_busy == 1'b0, "R10 busy cleared by repeated start", xfer_busy, 0);
    send_byte({DEV, 1'b0}, ak, st);
    check(ak == 1'b1, "R10 address after repeated start acked", ak, 1);
    send_byte(8'h9A, ak, st);
    send_byte(8'hBC, ak, st);
    send_byte(8'hDE, ak, st);
    bus_stop();
    check(got_cnt == base + 1, "R10 one word", got_cnt - base, 1);
    check(got_word == 24'h9ABCDE, "R10 word from new transfer", got_word, 24'h9ABCDE);

    // R2: bytes after stop without start are ignored
    base = got_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, ak, st);
    send_byte(8'h11, ak, st);
    bus_stop();
    check(xfer_busy == 1'b0, "R2 busy cleared by stop", xfer_busy, 0);
    m_scl = 1'b0; wait_clk(Q);
    send_byte(8'h5A, ak, st);
    check(ak == 1'b0, "R2 no ack without start", ak, 0);
    send_byte(8'h5B, ak, st);
    send_byte(8'h5C, ak, st);
    bus_stop();
    check(got_cnt == base, "R2 no word after stop", got_cnt - base, 0);

    // R3: programmable address change
    dev_addr = 7'h15;
    bus_start();
    send_byte({7'h15, 1'b0}, ak, st);
    check(ak == 1'b1, "R3 new device address acked", ak, 1);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b0}, ak, st);
    check(ak == 1'b0, "R3 old device address refused", ak, 0);
    bus_stop();
    bus_start();
    send_byte({BCAST, 1'b0}, ak, st);
    check(ak == 1'b1, "R4 broadcast still acked", ak, 1);
    bus_stop();
    dev_addr = DEV;

    // R12: back-pressure and overwrite
    word_ready = 1'b0;
    base = got_cnt;
    xfer(DEV, 24'h112233);
    check(word_valid == 1'b1, "R12 valid held", word_valid, 1);
    check(word_data == 24'h112233, "R12 data held", word_data, 24'h112233);
    wait_clk(50);
    check(word_valid == 1'b1, "R12 valid still held", word_valid, 1);
    check(word_data == 24'h112233, "R12 data still stable", word_data, 24'h112233);
    xfer(DEV, 24'h445566);
    check(word_data == 24'h445566, "R12 newer word replaces pending", word_data, 24'h445566);
    check(got_cnt == base, "R12 no handshake while not ready", got_cnt - base, 0);
    @(posedge clk);
    #2 word_ready = 1'b1;
    wait_clk(3);
    check(word_valid == 1'b0, "R12 valid drops after handshake", word_valid, 0);
    check(got_cnt == base + 1, "R12 exactly one handshake", got_cnt - base, 1);
    check(got_word == 24'h445566, "R12 handed word", got_word, 24'h445566);

    check(viol == 0, "R11 drive rose while SCL high", viol, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule